// File: doc/BRIEF.md
# Descriptor-Ring Scatter Receive DMA

This block moves received frame words from a MAC-side stream into system memory. Software places a ring of descriptors in memory. Each descriptor names a buffer pointer and a buffer size. Software gives the engine the ring base address and the number of entries. It hands descriptors over by moving a produce index forward. The engine takes descriptors in ring order and fills each buffer with consecutive words. When a buffer is full, or the frame ends, it writes a status word back into that descriptor and moves its consume index forward. A frame longer than one buffer is spread over as many descriptors as needed.

The engine owns one memory port. Each cycle it issues a single read or a single write, and read data comes back on the next cycle. The stream side has a ready signal, which is held low while a descriptor is being fetched or a status word is being written. When no descriptor is free, the engine still accepts the words and throws them away, and it raises an overrun flag.

Top module: `rxd_ring_dma`

## Requirements
- R1: Descriptor i starts at word address cfg_base + 4*i. Its word 0 holds the buffer pointer and its word 1 holds the buffer size in words, which must be at least 1. Both words are read before the first word of the buffer is accepted, and rx_ready stays low while they are read.
- R2: Word k of a buffer (k counted from 0) is written to address pointer + k, with rx_data as the write data, in the same cycle the word is accepted.
- R3: When a buffer fills before the frame ends, a status word is written to descriptor word 2. It has bit 31 (last) = 0, bit 30 (error) = 0 and bits 29:0 = buffer size. The frame then continues into the next descriptor.
- R4: On the last word of a frame, the status word is written with bit 31 = 1 and bits 29:0 = the number of words in that final buffer. This includes a frame that ends exactly on a full buffer.
- R5: Status bit 30 copies rx_err as sampled with the frame's last word.
- R6: cons_idx moves forward by one after each status write, and wraps from cfg_cnt-1 to 0.
- R7: The descriptor at cons_idx may be used only when cons_idx != sw_prod. A frame that starts with no usable descriptor is accepted in full, causes no memory write, and sets ovr_flag.
- R8: When the consume index reaches sw_prod in the middle of a frame, the rest of the frame is accepted and dropped with no memory write, and ovr_flag is set.
- R9: ovr_flag stays set until a later frame starts with a usable descriptor, and is cleared at that point.
- R10: After reset, rx_ready, mem_rd, mem_wr and ovr_flag are 0 and cons_idx is 0. mem_rd and mem_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_base | input | DW | Word address of descriptor 0 |
| cfg_cnt | input | IW | Number of ring entries |
| sw_prod | input | IW | Produce index, the limit released by software |
| cons_idx | output | IW | Consume index: the next descriptor the engine will fill |
| rx_valid | input | 1 | A stream word is present |
| rx_ready | output | 1 | The engine accepts the word this cycle |
| rx_data | input | DW | Stream word |
| rx_last | input | 1 | Marks the last word of a frame |
| rx_err | input | 1 | Frame error, qualified by rx_last |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | DW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Read data, valid the cycle after mem_rd |
| ovr_flag | output | 1 | Sticky overrun indication |

## Verification
A data write shows up on the memory port in the same cycle its word is accepted. A status write comes exactly one cycle after the word that closed the buffer. cons_idx changes at the clock edge that ends the status cycle, and the first word of a frame is accepted at the earliest four cycles after rx_valid rises. The scoreboard does not depend on these gaps for ordering: it compares every memory write, in order, against a queue of expected addresses and data. Both the inputs and the compared outputs are stable at the point where it samples them, between edges. The final cons_idx and ovr_flag are checked a few idle cycles after each frame, so that the last status write has taken effect.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
   typedef enum logic [2:0] {
      S_IDLE, S_RDPTR, S_RDSZ, S_LDSZ, S_FILL, S_STAT, S_DROP
   } rxd_state_e;
endpackage

// File: rtl/rxd_ring_idx.sv
module rxd_ring_idx #(
   parameter int IW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] cfg_cnt,
   input  logic [IW-1:0] sw_prod,
   input  logic          adv,
   output logic [IW-1:0] cons_idx,
   output logic          avail,
   output logic          nxt_avail
);
   logic [IW-1:0] c_q, c_nx;

   assign c_nx      = (c_q == cfg_cnt - 1'b1) ? '0 : c_q + 1'b1;
   assign avail     = (c_q != sw_prod);
   assign nxt_avail = (c_nx != sw_prod);
   assign cons_idx  = c_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   c_q <= '0;
      else if (adv) c_q <= c_nx;
   end

   // R6: each advance moves the index, and it stays inside the ring
   p_idx_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && cfg_cnt > 1) |=> (cons_idx != $past(cons_idx)));
   p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_cnt != 0 && $stable(cfg_cnt) && cons_idx < cfg_cnt) |=> (cons_idx < cfg_cnt));
endmodule

// File: rtl/rxd_frag_ctrl.sv
module rxd_frag_ctrl
   import rxd_pkg::*;
#(
   parameter int DW     = 32,
   parameter int IW     = 8,
   parameter int DESC_W = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] cfg_base,
   input  logic [IW-1:0] cons_idx,
   input  logic          avail,
   input  logic          nxt_avail,
   output logic          adv,
   input  logic          rx_valid,
   output logic          rx_ready,
   input  logic [DW-1:0] rx_data,
   input  logic          rx_last,
   input  logic          rx_err,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [DW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          ovr_flag
);
   localparam int CW       = DW - 2;
   localparam bit DESC_P2  = ((DESC_W & (DESC_W - 1)) == 0);

   rxd_state_e    st_q, st_nx;
   logic [DW-1:0] ptr_q, size_q, desc_off, desc_addr;
   logic [CW-1:0] cnt_q, cnt_inc;
   logic          last_q, err_q, ovr_q;
   logic          take;

   generate
      if (DESC_P2) begin : g_off_shift
         assign desc_off = DW'(cons_idx) << $clog2(DESC_W);
      end else begin : g_off_mul
         assign desc_off = DW'(cons_idx) * DW'(DESC_W);
      end
   endgenerate

   assign desc_addr = cfg_base + desc_off;
   assign cnt_inc   = cnt_q + 1'b1;
   assign take      = rx_valid && rx_ready;
   assign ovr_flag  = ovr_q;

   always_comb begin
      st_nx     = st_q;
      rx_ready  = 1'b0;
      mem_rd    = 1'b0;
      mem_wr    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      adv       = 1'b0;
      unique case (st_q)
         S_IDLE:  if (rx_valid) st_nx = avail ? S_RDPTR : S_DROP;
         S_RDPTR: begin
            mem_rd   = 1'b1;
            mem_addr = desc_addr;
            st_nx    = S_RDSZ;
         end
         S_RDSZ: begin
            mem_rd   = 1'b1;
            mem_addr = desc_addr + DW'(1);
            st_nx    = S_LDSZ;
         end
         S_LDSZ:  st_nx = S_FILL;
         S_FILL: begin
            rx_ready = 1'b1;
            if (rx_valid) begin
               mem_wr    = 1'b1;
               mem_addr  = ptr_q + DW'(cnt_q);
               mem_wdata = rx_data;
               if (rx_last || ({2'b00, cnt_inc} == size_q)) st_nx = S_STAT;
            end
         end
         S_STAT: begin
            mem_wr    = 1'b1;
            mem_addr  = desc_addr + DW'(2);
            mem_wdata = {last_q, err_q, cnt_q};
            adv       = 1'b1;
            if (last_q)          st_nx = S_IDLE;
            else if (!nxt_avail) st_nx = S_DROP;
            else                 st_nx = S_RDPTR;
         end
         S_DROP: begin
            rx_ready = 1'b1;
            if (rx_valid && rx_last) st_nx = S_IDLE;
         end
         default: st_nx = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         ptr_q  <= '0;
         size_q <= '0;
         cnt_q  <= '0;
         last_q <= 1'b0;
         err_q  <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         st_q <= st_nx;
         case (st_q)
            S_IDLE: if (rx_valid) ovr_q <= !avail;
            S_RDSZ: ptr_q <= mem_rdata;
            S_LDSZ: begin
               size_q <= mem_rdata;
               cnt_q  <= '0;
               last_q <= 1'b0;
               err_q  <= 1'b0;
            end
            S_FILL: if (take) begin
               cnt_q  <= cnt_inc;
               last_q <= rx_last;
               err_q  <= rx_last && rx_err;
            end
            S_STAT: begin
               cnt_q <= '0;
               if (!last_q && !nxt_avail) ovr_q <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   // R10: a single memory port, never read and write together
   p_port_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));
   // R7 / R8: words taken while dropping never reach memory
   p_drop_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_DROP) |-> !mem_wr);
   // R3: the fill count stays below the buffer size
   p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_FILL) |-> ({2'b00, cnt_q} < size_q));
   // R9: the overrun flag rises only on entry to dropping
   p_ovr_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q) |-> (st_q == S_DROP));
   // R1: the stream is held off while a descriptor is read
   p_fetch_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> !rx_ready);
endmodule

// File: rtl/rxd_ring_dma.sv
module rxd_ring_dma #(
   parameter int DW     = 32,
   parameter int IW     = 8,
   parameter int DESC_W = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] cfg_base,
   input  logic [IW-1:0] cfg_cnt,
   input  logic [IW-1:0] sw_prod,
   output logic [IW-1:0] cons_idx,
   input  logic          rx_valid,
   output logic          rx_ready,
   input  logic [DW-1:0] rx_data,
   input  logic          rx_last,
   input  logic          rx_err,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [DW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          ovr_flag
);
   generate
      if (DW < 8)     begin : g_bad_dw   $error("DW must be at least 8");   end
      if (IW < 1)     begin : g_bad_iw   $error("IW must be at least 1");   end
      if (DESC_W < 3) begin : g_bad_desc $error("DESC_W must be at least 3"); end
   endgenerate

   logic avail, nxt_avail, adv;

   rxd_ring_idx #(.IW(IW)) u_idx (
      .clk(clk), .rst_n(rst_n), .cfg_cnt(cfg_cnt), .sw_prod(sw_prod),
      .adv(adv), .cons_idx(cons_idx), .avail(avail), .nxt_avail(nxt_avail)
   );

   rxd_frag_ctrl #(.DW(DW), .IW(IW), .DESC_W(DESC_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cons_idx(cons_idx),
      .avail(avail), .nxt_avail(nxt_avail), .adv(adv),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
      .rx_last(rx_last), .rx_err(rx_err),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ovr_flag(ovr_flag)
   );
endmodule

// File: tb/rxd_ring_dma_tb.sv
module rxd_ring_dma_tb;
   localparam int DW   = 32;
   localparam int IW   = 8;
   localparam int NENT = 4;
   localparam logic [31:0] BASE = 32'h100;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [IW-1:0] sw_prod = '0;
   logic [IW-1:0] cons_idx;
   logic          rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0;
   logic [DW-1:0] rx_data = '0;
   logic          rx_ready, mem_rd, mem_wr, ovr_flag;
   logic [DW-1:0] mem_addr, mem_wdata, mem_rdata;

   logic [31:0] mem [0:4095];
   int total = 0, bad = 0, cyc = 0;
   bit done = 0;

   logic [31:0] q_addr[$], q_data[$];
   string       q_tag[$];

   logic [31:0] d_ptr [NENT];
   logic [31:0] d_size[NENT];
   int  m_c = 0, m_p = 0;
   bit  m_ovr = 0;

   always #4 clk = ~clk;

   rxd_ring_dma #(.DW(DW), .IW(IW), .DESC_W(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_base(BASE), .cfg_cnt(IW'(NENT)),
      .sw_prod(sw_prod), .cons_idx(cons_idx), .rx_valid(rx_valid),
      .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ovr_flag(ovr_flag)
   );

   always @(posedge clk) begin
      if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
   end

   // monitor: compare each memory write against the scoreboard queue
   always begin
      @(negedge clk); #2;
      if (rst_n && mem_wr) begin
         total++;
         if (q_addr.size() == 0) begin
            bad++;
            $display("FAIL R7 R8 unexpected write addr=%h data=%h expected none", mem_addr, mem_wdata);
         end else begin
            automatic logic [31:0] ea = q_addr.pop_front();
            automatic logic [31:0] ed = q_data.pop_front();
            automatic string       et = q_tag.pop_front();
            if (mem_addr !== ea || mem_wdata !== ed) begin
               bad++;
               $display("FAIL %s write addr=%h data=%h expected addr=%h data=%h",
                        et, mem_addr, mem_wdata, ea, ed);
            end
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         total++; bad++;
         $display("FAIL R1 watchdog expired actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int nxt(input int i);
      return (i == NENT - 1) ? 0 : i + 1;
   endfunction

   function automatic logic [31:0] wval(input int f, input int w);
      return 32'hA000_0000 | (f << 8) | w;
   endfunction

   // driver: push the expected writes, then present the frame
   task automatic send_frame(input int f, input int len, input bit err);
      int  k = 0;
      bit  drop = 0;
      if (m_c == m_p) begin drop = 1; m_ovr = 1; end
      else m_ovr = 0;
      for (int w = 0; w < len; w++) begin
         if (drop) continue;
         q_addr.push_back(d_ptr[m_c] + k); q_data.push_back(wval(f, w)); q_tag.push_back("R2");
         k++;
         if (w == len - 1) begin
            q_addr.push_back(BASE + m_c * 4 + 2);
            q_data.push_back({1'b1, err, 30'(k)}); q_tag.push_back("R4 R5");
            m_c = nxt(m_c);
         end else if (k == d_size[m_c]) begin
            q_addr.push_back(BASE + m_c * 4 + 2);
            q_data.push_back({2'b00, 30'(k)}); q_tag.push_back("R3");
            m_c = nxt(m_c); k = 0;
            if (m_c == m_p) begin drop = 1; m_ovr = 1; end
         end
      end
      for (int w = 0; w < len; w++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_data = wval(f, w);
         rx_last = (w == len - 1); rx_err = (w == len - 1) ? err : 1'b0;
         while (!rx_ready) @(negedge clk);
         @(posedge clk);
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
      repeat (4) @(negedge clk);
      check("R6 cons_idx", 32'(cons_idx), 32'(m_c));
      check("R7 R8 R9 ovr_flag", 32'(ovr_flag), 32'(m_ovr));
      check("R2 queue drained", 32'(q_addr.size()), 0);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = '0;
      d_size[0] = 3; d_size[1] = 5; d_size[2] = 2; d_size[3] = 4;
      for (int i = 0; i < NENT; i++) begin
         d_ptr[i] = 32'h200 + i * 32'h40;
         mem[BASE + i * 4]     = d_ptr[i];
         mem[BASE + i * 4 + 1] = d_size[i];
      end
      m_p = 3; sw_prod = 3;
      repeat (3) @(negedge clk);
      check("R10 reset rx_ready", 32'(rx_ready), 0);
      check("R10 reset cons_idx", 32'(cons_idx), 0);
      check("R10 reset ovr_flag", 32'(ovr_flag), 0);
      check("R10 reset mem strobes", 32'({mem_rd, mem_wr}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      send_frame(1, 2, 0);   // R4: short frame in one buffer
      send_frame(2, 7, 1);   // R3 R5: split over two buffers, error
      send_frame(3, 3, 0);   // R7: ring empty, whole frame dropped
      @(negedge clk); m_p = 1; sw_prod = 1;
      send_frame(4, 4, 0);   // R4 R6: exact fill, index wraps to 0
      send_frame(5, 5, 0);   // R8: exhausted mid frame
      @(negedge clk); m_p = 0; sw_prod = 0;
      send_frame(6, 1, 0);   // R9: flag cleared on next stored frame
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule